// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog peripheral on a plain 32-bit register bus. A counter advances once for each pulse of a slow tick-enable input, but only while one of two run modes is selected: run unconditionally, or run only while the core reports that it is awake. A barrel shifter divides the count by a programmable power of two. The 16-bit result is compared against a programmable threshold. When the threshold is reached, a sticky pending flag in the configuration word is set and drives the interrupt output. A one-cycle system reset request can also be raised, and the count can be cleared so that it starts a new period.

Software must write a key word before each change to the configuration, count, feed or threshold registers. Every such write uses up the key, whether or not it lands. A write of the feed constant to the feed register restarts the count. The key value and the feed value are parameters.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the configuration reads 0, the count reads 0, the key register reads 0, the threshold (offset 0x20) reads 0x0000BEEF and `irq` is low.
- R2: Only accesses with `bus_be` equal to 4'hF are honoured. A write with any other byte mask changes no state, including the key flag, and a read with one returns 0.
- R3: Writing KEY_VAL to offset 0x1C sets the key flag, and any other value leaves it unchanged. A read of 0x1C returns the flag in bit 0 with all other bits 0.
- R4: Writes to 0x00 (config), 0x08 (count), 0x18 (feed) and 0x20 (threshold, low 16 bits stored) take effect only while the key flag is set. Every such write clears the flag, including one that is dropped because the flag was clear.
- R5: The count (offset 0x08) is 31 bits wide, and bit 31 always reads 0. On a cycle with `tick` high it advances by one, wrapping from 0x7FFFFFFF to 0, if config bit 12 is set, or if config bit 13 is set and `core_awake` is high.
- R6: Offset 0x10 reads (count >> scale) truncated to 16 bits, where scale is config bits 3:0. Writes to 0x10 change nothing and leave the key flag as it is.
- R7: While the scaled value is greater than or equal to the threshold, config bit 28 (pending) is set on the next clock edge and then stays set. A config write loads bit 28 from the written data, but a match in that cycle still sets it. `irq` equals bit 28.
- R8: If config bit 8 is set, `rst_req` is high for exactly the first cycle in which the scaled value is greater than or equal to the threshold.
- R9: If config bit 9 is set and the scaled value is greater than or equal to the threshold, the count is cleared on the next clock edge.
- R10: A write of FEED_VAL to 0x18 while the key flag is set clears the count. Any other value leaves the count as it is. A read of 0x18 returns 0.
- R11: A config read returns only bits 28, 13, 12, 9, 8 and 3:0, and all other bits read 0. For the count, an accepted count write beats a feed, a feed beats the match clear, and the match clear beats a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | 4 | Byte mask; only 4'hF is honoured |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| tick | input | 1 | Slow watchdog tick enable |
| core_awake | input | 1 | Core-awake qualifier for the conditional run mode |
| irq | output | 1 | Interrupt, equal to the pending bit |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is a threshold match with the reset request and the match clear both enabled. It has to coincide with traffic that moves the key, the threshold and the count, because each of those changes needs its own fresh key write first. The random stimulus writes the key in about a quarter of all cycles and uses the correct value most of the time. It keeps thresholds and scales small and seeds counts near the threshold or near the top of the 31-bit range, so that matches, wraps and locked drops all occur often. Directed sequences then set up each boundary on its own.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int unsigned SCALE_W = 4;

   localparam logic [7:0] OFS_CFG  = 8'h00;
   localparam logic [7:0] OFS_CNT  = 8'h08;
   localparam logic [7:0] OFS_SCL  = 8'h10;
   localparam logic [7:0] OFS_FEED = 8'h18;
   localparam logic [7:0] OFS_KEY  = 8'h1C;
   localparam logic [7:0] OFS_THR  = 8'h20;

   localparam int unsigned BIT_RST_EN  = 8;
   localparam int unsigned BIT_ZWRAP   = 9;
   localparam int unsigned BIT_RUN_ALW = 12;
   localparam int unsigned BIT_RUN_AWK = 13;
   localparam int unsigned BIT_PEND    = 28;

   typedef struct packed {
      logic               pend;
      logic               run_awake;
      logic               run_always;
      logic               zero_wrap;
      logic               rst_en;
      logic [SCALE_W-1:0] scale;
   } cfg_t;

   function automatic logic [31:0] cfg_pack(input cfg_t c);
      return {3'b000, c.pend, 14'd0, c.run_awake, c.run_always,
              2'b00, c.zero_wrap, c.rst_en, 4'b0000, c.scale};
   endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             feed,
   input  logic             wrap_clr,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (feed || wrap_clr) begin
         count_q <= '0;
      end else if (tick && run) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count = count_q;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !feed && !wrap_clr && tick && run) |=> count_q == CNT_W'($past(count_q) + 1'b1)); // R5

   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !feed && !wrap_clr && !(tick && run)) |=> $stable(count_q)); // R5

   AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_clr && !load) |=> count_q == '0); // R9

endmodule

// File: rtl/wdt_compare.sv
module wdt_compare #(
   parameter int unsigned CNT_W   = 31,
   parameter int unsigned CMP_W   = 16,
   parameter int unsigned SCALE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   count,
   input  logic [SCALE_W-1:0] scale,
   input  logic [CMP_W-1:0]   thresh,
   input  logic               rst_en,
   output logic [CMP_W-1:0]   scaled,
   output logic               hit,
   output logic               rst_req
);

   logic [CNT_W-1:0] stg [SCALE_W+1];
   logic             hit_q;

   assign stg[0] = count;

   for (genvar i = 0; i < SCALE_W; i++) begin : g_shift
      assign stg[i+1] = scale[i] ? (stg[i] >> (1 << i)) : stg[i];
   end

   assign scaled  = stg[SCALE_W][CMP_W-1:0];
   assign hit     = (scaled >= thresh);
   assign rst_req = rst_en && hit && !hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= hit;
   end

   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R8

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 31,
   parameter int unsigned CMP_W    = 16,
   parameter logic [31:0] KEY_VAL  = 32'h4B45_5921,
   parameter logic [31:0] FEED_VAL = 32'hFEED_0A11,
   parameter logic [31:0] THR_INIT = 32'h0000_BEEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic [CMP_W-1:0]  scaled,
   input  logic              hit,
   output cfg_t              cfg,
   output logic [CMP_W-1:0]  thresh,
   output logic              cnt_load,
   output logic [CNT_W-1:0]  cnt_load_val,
   output logic              cnt_feed
);

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
   localparam logic [ADDR_W-1:0] A_SCL  = ADDR_W'(OFS_SCL);
   localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(OFS_FEED);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
   localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(OFS_THR);

   cfg_t             cfg_q;
   logic [CMP_W-1:0] thr_q;
   logic             unlock_q;

   logic full_word, wr, rd;
   logic sel_cfg, sel_cnt, sel_scl, sel_feed, sel_key, sel_thr;
   logic prot, acc_cfg, acc_cnt, acc_feed, acc_thr, key_ok;

   assign full_word = (bus_be == 4'hF);
   assign wr        = bus_valid && bus_write && full_word;
   assign rd        = bus_valid && !bus_write && full_word;

   assign sel_cfg  = (bus_addr == A_CFG);
   assign sel_cnt  = (bus_addr == A_CNT);
   assign sel_scl  = (bus_addr == A_SCL);
   assign sel_feed = (bus_addr == A_FEED);
   assign sel_key  = (bus_addr == A_KEY);
   assign sel_thr  = (bus_addr == A_THR);

   assign prot     = wr && (sel_cfg || sel_cnt || sel_feed || sel_thr);
   assign acc_cfg  = prot && unlock_q && sel_cfg;
   assign acc_cnt  = prot && unlock_q && sel_cnt;
   assign acc_feed = prot && unlock_q && sel_feed;
   assign acc_thr  = prot && unlock_q && sel_thr;
   assign key_ok   = wr && sel_key && (bus_wdata == KEY_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         thr_q    <= CMP_W'(THR_INIT);
         unlock_q <= 1'b0;
      end else begin
         if (prot)        unlock_q <= 1'b0;
         else if (key_ok) unlock_q <= 1'b1;

         if (acc_cfg) begin
            cfg_q.scale      <= bus_wdata[SCALE_W-1:0];
            cfg_q.rst_en     <= bus_wdata[BIT_RST_EN];
            cfg_q.zero_wrap  <= bus_wdata[BIT_ZWRAP];
            cfg_q.run_always <= bus_wdata[BIT_RUN_ALW];
            cfg_q.run_awake  <= bus_wdata[BIT_RUN_AWK];
         end
         cfg_q.pend <= (acc_cfg ? bus_wdata[BIT_PEND] : cfg_q.pend) | hit;

         if (acc_thr) thr_q <= bus_wdata[CMP_W-1:0];
      end
   end

   assign cfg          = cfg_q;
   assign thresh       = thr_q;
   assign cnt_load     = acc_cnt;
   assign cnt_load_val = bus_wdata[CNT_W-1:0];
   assign cnt_feed     = acc_feed && (bus_wdata == FEED_VAL);

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         unique case (1'b1)
            sel_cfg: bus_rdata = cfg_pack(cfg_q);
            sel_cnt: bus_rdata = 32'(count);
            sel_scl: bus_rdata = 32'(scaled);
            sel_key: bus_rdata = {31'd0, unlock_q};
            sel_thr: bus_rdata = 32'(thr_q);
            default: bus_rdata = '0;
         endcase
      end
   end

   AST_RELOCK_ON_USE: assert property (@(posedge clk) disable iff (!rst_n)
      prot |=> !unlock_q); // R4

   AST_LOCKED_THR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (prot && !unlock_q && sel_thr) |=> $stable(thr_q)); // R4

   AST_PARTIAL_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && !full_word && !unlock_q) |=> !unlock_q); // R2

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.pend && !acc_cfg) |=> cfg_q.pend); // R7

   AST_HIT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> cfg_q.pend); // R7

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 31,
   parameter int unsigned CMP_W    = 16,
   parameter logic [31:0] KEY_VAL  = 32'h4B45_5921,
   parameter logic [31:0] FEED_VAL = 32'hFEED_0A11,
   parameter logic [31:0] THR_INIT = 32'h0000_BEEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tick,
   input  logic              core_awake,
   output logic              irq,
   output logic              rst_req
);

   initial begin
      assert (CNT_W <= 31 && CNT_W >= CMP_W)
         else $error("wdt_keyed: CNT_W must lie between CMP_W and 31");
      assert (CMP_W >= 1 && CMP_W <= 16)
         else $error("wdt_keyed: CMP_W must lie between 1 and 16");
      assert (ADDR_W >= 6)
         else $error("wdt_keyed: ADDR_W too small for the register offsets");
   end

   cfg_t             cfg;
   logic [CMP_W-1:0] thresh, scaled;
   logic [CNT_W-1:0] count, cnt_load_val;
   logic             cnt_load, cnt_feed, hit, run;

   wdt_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMP_W(CMP_W),
      .KEY_VAL(KEY_VAL), .FEED_VAL(FEED_VAL), .THR_INIT(THR_INIT)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count(count), .scaled(scaled), .hit(hit),
      .cfg(cfg), .thresh(thresh),
      .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .cnt_feed(cnt_feed)
   );

   assign run = cfg.run_always || (cfg.run_awake && core_awake);

   wdt_counter #(.CNT_W(CNT_W)) i_counter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
      .load(cnt_load), .load_val(cnt_load_val), .feed(cnt_feed),
      .wrap_clr(hit && cfg.zero_wrap), .count(count)
   );

   wdt_compare #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) i_compare (
      .clk(clk), .rst_n(rst_n), .count(count), .scale(cfg.scale),
      .thresh(thresh), .rst_en(cfg.rst_en),
      .scaled(scaled), .hit(hit), .rst_req(rst_req)
   );

   assign irq = cfg.pend;

endmodule

// File: tb/test_wdt_keyed.sv
`timescale 1ns/1ps
module test_wdt_keyed;

   localparam logic [31:0] KEY  = 32'h4B45_5921;
   localparam logic [31:0] FEED = 32'hFEED_0A11;
   localparam logic [7:0] A_CFG = 8'h00, A_CNT = 8'h08, A_SCL = 8'h10,
                          A_FEED = 8'h18, A_KEY = 8'h1C, A_THR = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick = 1'b0, core_awake = 1'b0;
   logic        irq, rst_req;

   always #10 clk = ~clk;

   wdt_keyed i_wdt_keyed (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tick(tick), .core_awake(core_awake),
      .irq(irq), .rst_req(rst_req)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_tag  = "";

   // expected-state model
   logic [31:0] m_cnt;
   logic [3:0]  m_scale;
   logic        m_rsten, m_zw, m_alw, m_awk, m_pend, m_unl, m_hitq;
   logic [15:0] m_thr;

   function automatic logic [15:0] m_scaled();
      logic [31:0] s;
      s = m_cnt >> m_scale;
      return s[15:0];
   endfunction

   function automatic logic m_hit();
      return m_scaled() >= m_thr;
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [3:0] be);
      if (be != 4'hF) return 32'd0;
      case (a)
         A_CFG:  return {3'b0, m_pend, 14'd0, m_awk, m_alw, 2'b0, m_zw, m_rsten, 4'b0, m_scale};
         A_CNT:  return m_cnt;
         A_SCL:  return {16'd0, m_scaled()};
         A_KEY:  return {31'd0, m_unl};
         A_THR:  return {16'd0, m_thr};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string addr_tag(input logic [7:0] a, input logic [3:0] be);
      if (be != 4'hF) return "R2";
      case (a)
         A_CFG:  return "R11";
         A_CNT:  return "R5";
         A_SCL:  return "R6";
         A_FEED: return "R10";
         A_KEY:  return "R3";
         A_THR:  return "R4";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cnt = '0; m_scale = '0; m_rsten = 0; m_zw = 0; m_alw = 0; m_awk = 0;
      m_pend = 0; m_unl = 0; m_hitq = 0; m_thr = 16'hBEEF;
   endtask

   task automatic step(input logic v, input logic we, input logic [7:0] a,
                       input logic [3:0] be, input logic [31:0] d,
                       input logic tk, input logic aw);
      logic full, wr, prot, ok, hit, run;
      @(negedge clk);
      bus_valid = v; bus_write = we; bus_addr = a; bus_be = be; bus_wdata = d;
      tick = tk; core_awake = aw;
      #2;
      hit = m_hit();
      chk((cur_tag != "") ? cur_tag : "R7", {31'd0, irq}, {31'd0, m_pend});
      chk((cur_tag != "") ? cur_tag : "R8", {31'd0, rst_req}, {31'd0, m_rsten & hit & ~m_hitq});
      if (v && !we)
         chk((cur_tag != "") ? cur_tag : addr_tag(a, be), bus_rdata, exp_read(a, be));
      @(posedge clk);
      full = (be == 4'hF);
      wr   = v && we && full;
      prot = wr && (a == A_CFG || a == A_CNT || a == A_FEED || a == A_THR);
      ok   = prot && m_unl;
      run  = m_alw | (m_awk & aw);
      if (ok && a == A_CNT)                    m_cnt = d & 32'h7FFF_FFFF;
      else if (ok && a == A_FEED && d == FEED) m_cnt = 0;
      else if (hit && m_zw)                    m_cnt = 0;
      else if (tk && run)                      m_cnt = (m_cnt + 1) & 32'h7FFF_FFFF;
      if (ok && a == A_CFG) begin
         m_scale = d[3:0]; m_rsten = d[8]; m_zw = d[9]; m_alw = d[12]; m_awk = d[13];
         m_pend = d[28] | hit;
      end else begin
         m_pend = m_pend | hit;
      end
      if (ok && a == A_THR) m_thr = d[15:0];
      if (prot) m_unl = 0;
      else if (wr && a == A_KEY && d == KEY) m_unl = 1;
      m_hitq = hit;
   endtask

   task automatic rd(input logic [7:0] a);
      step(1, 0, a, 4'hF, 0, 0, 0);
   endtask

   task automatic kw(input logic [7:0] a, input logic [31:0] d);
      step(1, 1, A_KEY, 4'hF, KEY, 0, 0);
      step(1, 1, a, 4'hF, d, 0, 0);
   endtask

   task automatic idle(input int n, input logic tk, input logic aw);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tk, aw);
   endtask

   logic [7:0] addrs [7] = '{A_CFG, A_CNT, A_SCL, A_FEED, A_KEY, A_THR, 8'h04};
   bit done = 0;

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(20240611);
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cur_tag = "R1";
      rd(A_CFG); rd(A_CNT); rd(A_KEY); rd(A_THR); rd(A_SCL);

      // R2 partial accesses
      cur_tag = "R2";
      step(1, 1, A_KEY, 4'h7, KEY, 0, 0);
      rd(A_KEY);
      step(1, 0, A_THR, 4'h3, 0, 0, 0);

      // R3 key, R4 lock behaviour
      cur_tag = "R3";
      step(1, 1, A_KEY, 4'hF, KEY, 0, 0);
      rd(A_KEY);
      step(1, 1, A_KEY, 4'hF, 32'h1234_5678, 0, 0);
      rd(A_KEY);
      cur_tag = "R4";
      step(1, 1, A_THR, 4'hF, 32'hABCD_0005, 0, 0);
      rd(A_THR); rd(A_KEY);
      step(1, 1, A_THR, 4'hF, 32'd9, 0, 0);
      rd(A_THR); rd(A_KEY);

      // R5 counting modes and 31-bit wrap
      cur_tag = "R5";
      kw(A_THR, 32'hFFFF);
      kw(A_CFG, 32'h0000_1000);
      idle(3, 1, 0);
      rd(A_CNT);
      kw(A_CFG, 32'h0000_2000);
      idle(3, 1, 0);
      rd(A_CNT);
      idle(2, 1, 1);
      rd(A_CNT);
      kw(A_CFG, 32'h0000_1004);
      kw(A_CNT, 32'hFFFF_FFFF);
      rd(A_CNT);
      idle(1, 1, 0);
      rd(A_CNT);

      // R6 scaled view, ignored write
      cur_tag = "R6";
      kw(A_CFG, 32'h0000_0002);
      kw(A_CNT, 32'd13);
      rd(A_SCL);
      step(1, 1, A_KEY, 4'hF, KEY, 0, 0);
      step(1, 1, A_SCL, 4'hF, 32'h0, 0, 0);
      rd(A_KEY); rd(A_SCL);
      step(1, 1, A_CFG, 4'hF, 32'h0, 0, 0);

      // R7/R8/R9 match with reset request and clear
      cur_tag = "R9";
      kw(A_THR, 32'd4);
      kw(A_CFG, 32'h0000_1300);
      rd(A_CFG);
      cur_tag = "R8";
      idle(6, 1, 0);
      cur_tag = "R9";
      rd(A_CNT);
      cur_tag = "R7";
      kw(A_CFG, 32'h0000_0000);
      rd(A_CFG);
      idle(2, 0, 0);

      // R10 feed
      cur_tag = "R10";
      kw(A_CNT, 32'd3);
      kw(A_FEED, 32'h1111_2222);
      rd(A_CNT);
      kw(A_FEED, FEED);
      rd(A_CNT); rd(A_FEED);

      // R11 config read mask and priority
      cur_tag = "R11";
      kw(A_THR, 32'hFFFF);
      kw(A_CFG, 32'hFFFF_FFFF);
      rd(A_CFG);
      kw(A_CFG, 32'h0000_1000);
      step(1, 1, A_KEY, 4'hF, KEY, 0, 0);
      step(1, 1, A_CNT, 4'hF, 32'd40, 1, 0);
      rd(A_CNT);
      step(1, 1, A_KEY, 4'hF, KEY, 0, 0);
      step(1, 1, A_FEED, 4'hF, FEED, 1, 0);
      rd(A_CNT);

      // constrained random phase
      cur_tag = "";
      for (int n = 0; n < 5000; n++) begin
         int unsigned r, s;
         logic tk, aw;
         logic [31:0] d;
         r  = $urandom_range(0, 99);
         tk = 1'($urandom_range(0, 1));
         aw = 1'($urandom_range(0, 1));
         if (r < 25) begin
            d = ($urandom_range(0, 7) == 0) ? $urandom : KEY;
            step(1, 1, A_KEY, ($urandom_range(0, 9) == 0) ? 4'h3 : 4'hF, d, tk, aw);
         end else if (r < 42) begin
            s = $urandom_range(0, 3);
            case (s)
               0: begin
                  d = $urandom;
                  d[3:0] = 4'($urandom_range(0, 3));
                  step(1, 1, A_CFG, 4'hF, d, tk, aw);
               end
               1: begin
                  d = ($urandom_range(0, 3) == 0) ? (32'hFFFF_FFF0 | 32'($urandom_range(0, 15)))
                                                  : 32'($urandom_range(0, 100));
                  step(1, 1, A_CNT, 4'hF, d, tk, aw);
               end
               2: step(1, 1, A_FEED, 4'hF, ($urandom_range(0, 9) < 7) ? FEED : $urandom, tk, aw);
               default: begin
                  d = ($urandom & 32'hFFFF_0000) | 32'($urandom_range(0, 60));
                  step(1, 1, A_THR, 4'hF, d, tk, aw);
               end
            endcase
         end else if (r < 48) begin
            step(1, 1, A_SCL, ($urandom_range(0, 3) == 0) ? 4'h1 : 4'hF, $urandom, tk, aw);
         end else if (r < 85) begin
            step(1, 0, addrs[$urandom_range(0, 6)],
                 ($urandom_range(0, 9) == 0) ? 4'hC : 4'hF, 0, tk, aw);
         end else begin
            step(0, 0, 0, 0, 0, tk, aw);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule